// File: doc/BRIEF.md
# Machine Status Register with Instruction Permission Traps

This block holds the 64-bit machine status word of a processor core and decides whether the instruction now issuing may run. Software updates the word through a single write port. Each write is masked, so only the defined control fields take the written value. Every other bit position is forced to zero and reads back as zero.

Alongside the register, a permission checker takes three class flags for the issuing instruction: needs supervisor rights, uses the floating-point unit, and is valid only with a 64-bit datapath. It also takes the current register-length mode. If the instruction is not allowed, the checker raises exactly one trap line on the following cycle.

The defined fields are:

| Bit(s) | Field |
|---|---|
| 0 | exception enable |
| 2 | previous supervisor |
| 3 | supervisor |
| 4 | floating-point enable |
| 5 | user 64-bit |
| 6 | supervisor 64-bit |
| 15..8 | interrupt mask |

Top module: `priv_status_trap`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0x0000_0000_0000_0008 (supervisor bit 3 set, every other bit clear), and all three trap outputs become 0.
- R2: When `wr_en` is high at a clock edge, the status word becomes `wr_data` AND 0x0000_0000_0000_FF7D, taking effect after that edge. The kept positions are bits 0, 2, 3, 4, 5, 6 and 15..8.
- R3: Bits 1, 7 and 63..16 of the status word read as zero at all times, whatever was written.
- R4: When `wr_en` is low at a clock edge, the status word keeps its value.
- R5: If `cls_priv` is high while status bit 3 is clear, `trap_priv` is high in the cycle after that edge.
- R6: If `cls_fp` is high while status bit 4 is clear, `trap_fpoff` is high in the cycle after that edge.
- R7: If `cls_wide` is high while `mode64` is low, `trap_illegal` is high in the cycle after that edge.
- R8: When several trap conditions hold together, only the highest-priority trap asserts. The order is illegal-instruction first, then privileged, then FP-disabled. At most one trap output is ever high.
- R9: The trap check at an edge where a write also happens uses the status value from before that write.
- R10: When no class flag has its condition met, all trap outputs are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | status write strobe |
| wr_data | input | 64 | status write value, before masking |
| cls_priv | input | 1 | issuing instruction needs supervisor rights |
| cls_fp | input | 1 | issuing instruction uses the floating-point unit |
| cls_wide | input | 1 | issuing instruction is valid only with a 64-bit datapath |
| mode64 | input | 1 | 1 = register length is 64, 0 = 32 |
| status_q | output | 64 | current status word |
| trap_illegal | output | 1 | illegal-instruction trap, registered |
| trap_priv | output | 1 | privileged-instruction trap, registered |
| trap_fpoff | output | 1 | floating-point-disabled trap, registered |

## Verification
The bench writes an all-ones word and a striped pattern to test the mask. A wrong mask would either leak bits 1, 7 or 16 and above into the readback, or drop a defined bit.

It clears the supervisor bit with the same write that issues a privileged instruction. A design that checked against the new value would trap one cycle early.

It issues instructions that break several rules at once. A design with the wrong priority, or without a one-hot encoder, would show two trap lines or the wrong one.

It also resets after a write. A design that reset to zero, instead of to supervisor-only, would then raise a spurious privileged trap.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

  // bit positions of the defined status fields
  localparam int BIT_EXC_EN  = 0;
  localparam int BIT_PREV_SU = 2;
  localparam int BIT_SU      = 3;
  localparam int BIT_FPU_EN  = 4;
  localparam int BIT_U64     = 5;
  localparam int BIT_S64     = 6;

  typedef struct packed {
    logic illegal;
    logic priv;
    logic fpoff;
  } trap_t;

  // write mask: single-bit fields plus an interrupt-mask field
  function automatic logic [63:0] keep_mask(input int irq_lsb, input int irq_w);
    logic [63:0] m;
    m = '0;
    m[BIT_EXC_EN]  = 1'b1;
    m[BIT_PREV_SU] = 1'b1;
    m[BIT_SU]      = 1'b1;
    m[BIT_FPU_EN]  = 1'b1;
    m[BIT_U64]     = 1'b1;
    m[BIT_S64]     = 1'b1;
    for (int i = 0; i < irq_w; i++) m[irq_lsb + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pstat_reg.sv
module pstat_reg #(
  parameter int          XLEN    = 64,
  parameter logic [XLEN-1:0] MASK    = '1,
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL & MASK;
    else if (wr_en) q <= wr_data & MASK;
  end

endmodule

// File: rtl/pstat_trapchk.sv
module pstat_trapchk
  import pstat_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  su,
  input  logic  fpu_en,
  input  logic  mode64,
  input  logic  cls_priv,
  input  logic  cls_fp,
  input  logic  cls_wide,
  output trap_t trap_q
);

  trap_t raw, sel;

  always_comb begin
    raw.illegal = cls_wide & ~mode64;
    raw.priv    = cls_priv & ~su;
    raw.fpoff   = cls_fp & ~fpu_en;
    // fixed priority: illegal > privileged > fp-disabled
    sel = '0;
    if (raw.illegal)   sel.illegal = 1'b1;
    else if (raw.priv) sel.priv    = 1'b1;
    else if (raw.fpoff) sel.fpoff  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) trap_q <= '0;
    else     trap_q <= sel;
  end

endmodule

// File: rtl/priv_status_trap.sv
module priv_status_trap
  import pstat_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IRQ_LSB = 8,
  parameter int IRQ_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            cls_priv,
  input  logic            cls_fp,
  input  logic            cls_wide,
  input  logic            mode64,
  output logic [XLEN-1:0] status_q,
  output logic            trap_illegal,
  output logic            trap_priv,
  output logic            trap_fpoff
);

  localparam logic [63:0]     FULL_MASK = keep_mask(IRQ_LSB, IRQ_W);
  localparam logic [XLEN-1:0] WMASK     = FULL_MASK[XLEN-1:0];
  localparam logic [XLEN-1:0] RST_VAL   = XLEN'(1) << BIT_SU;

  trap_t traps;

  pstat_reg #(.XLEN(XLEN), .MASK(WMASK), .RST_VAL(RST_VAL)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .q       (status_q)
  );

  // check sees the pre-write register value of the same cycle
  pstat_trapchk u_chk (
    .clk      (clk),
    .rst      (rst),
    .su       (status_q[BIT_SU]),
    .fpu_en   (status_q[BIT_FPU_EN]),
    .mode64   (mode64),
    .cls_priv (cls_priv),
    .cls_fp   (cls_fp),
    .cls_wide (cls_wide),
    .trap_q   (traps)
  );

  assign trap_illegal = traps.illegal;
  assign trap_priv    = traps.priv;
  assign trap_fpoff   = traps.fpoff;

endmodule

// File: rtl/pstat_checker.sv
module pstat_checker #(
  parameter int XLEN    = 64,
  parameter int IRQ_LSB = 8,
  parameter int IRQ_W   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data,
  input logic            cls_priv,
  input logic            cls_fp,
  input logic            cls_wide,
  input logic            mode64,
  input logic [XLEN-1:0] status_q,
  input logic            trap_illegal,
  input logic            trap_priv,
  input logic            trap_fpoff
);
  localparam logic [63:0]     FM = pstat_pkg::keep_mask(IRQ_LSB, IRQ_W);
  localparam logic [XLEN-1:0] M  = FM[XLEN-1:0];

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~M) == '0); // R3
  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status_q == ($past(wr_data) & M)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(status_q)); // R4
  AST_ONE_TRAP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_illegal, trap_priv, trap_fpoff})); // R8
  AST_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (cls_wide && !mode64) |=> trap_illegal); // R7
  AST_PRIV: assert property (@(posedge clk) disable iff (rst)
    (cls_priv && !status_q[3] && !(cls_wide && !mode64)) |=> trap_priv); // R5
  AST_FPOFF: assert property (@(posedge clk) disable iff (rst)
    (cls_fp && !status_q[4] && !(cls_wide && !mode64)
     && !(cls_priv && !status_q[3])) |=> trap_fpoff); // R6
  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!(cls_wide && !mode64) && !(cls_priv && !status_q[3]) && !(cls_fp && !status_q[4]))
    |=> !(trap_illegal || trap_priv || trap_fpoff)); // R10
endmodule

bind priv_status_trap pstat_checker #(.XLEN(XLEN), .IRQ_LSB(IRQ_LSB), .IRQ_W(IRQ_W)) u_pstat_chk (.*);

// File: tb/tb_priv_status_trap.sv
module tb_priv_status_trap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {we, data[63:0], priv, fp, wide, m64, exp_status[63:0], exp{ill,priv,fp}}
  localparam int VW = 1 + 64 + 4 + 64 + 3;

  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 64'h0,                   4'b1001, 64'h8,    3'b000}, // R10 supervisor ok
    {1'b0, 64'h0,                   4'b0101, 64'h8,    3'b001}, // R6
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1001, 64'hFF7D, 3'b000}, // R2 R3
    {1'b0, 64'h0,                   4'b1101, 64'hFF7D, 3'b000}, // R4 R10
    {1'b1, 64'h0,                   4'b1001, 64'h0,    3'b000}, // R9 old value used
    {1'b0, 64'h0,                   4'b1001, 64'h0,    3'b010}, // R5
    {1'b0, 64'h0,                   4'b1101, 64'h0,    3'b010}, // R8 priv over fp
    {1'b0, 64'h0,                   4'b1110, 64'h0,    3'b100}, // R7 R8
    {1'b0, 64'h0,                   4'b0011, 64'h0,    3'b000}, // R10 wide in 64
    {1'b1, 64'h0000_0000_0001_0010, 4'b0101, 64'h10,   3'b001}, // R3 R9
    {1'b0, 64'h0,                   4'b0101, 64'h10,   3'b000}, // R10
    {1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 4'b0000, 64'hAA28, 3'b000}, // R2 R3
    {1'b0, 64'h0,                   4'b0111, 64'hAA28, 3'b001}  // R6
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic cls_priv = 1'b0, cls_fp = 1'b0, cls_wide = 1'b0, mode64 = 1'b1;
  logic [63:0] status_q;
  logic trap_illegal, trap_priv, trap_fpoff;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_status_trap dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    step(); step();
    chk("R1 status", status_q, 64'h8);
    chk("R1 traps", {61'b0, trap_illegal, trap_priv, trap_fpoff}, 64'h0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, wr_data, cls_priv, cls_fp, cls_wide, mode64} = VEC[i][VW-1 -: 69];
      step();
      chk($sformatf("R2/R3/R4 status v%0d", i), status_q, VEC[i][66:3]);
      chk($sformatf("R5-R10 traps v%0d", i),
          {61'b0, trap_illegal, trap_priv, trap_fpoff}, {61'b0, VEC[i][2:0]});
    end
    // reset after a write restores supervisor-only and clears traps
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h0; cls_priv = 1'b1; cls_fp = 1'b0; cls_wide = 1'b0;
    step();
    @(negedge clk); wr_en = 1'b0;
    step();
    chk("R5 pre-reset trap", {63'b0, trap_priv}, 64'h1);
    @(negedge clk); rst = 1'b1;
    step();
    chk("R1 reset status", status_q, 64'h8);
    chk("R1 reset traps", {61'b0, trap_illegal, trap_priv, trap_fpoff}, 64'h0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R1 R10 no trap after reset", {61'b0, trap_illegal, trap_priv, trap_fpoff}, 64'h0);
    // all three conditions at once
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h0;
    step();
    @(negedge clk); wr_en = 1'b0; cls_priv = 1'b1; cls_fp = 1'b1; cls_wide = 1'b1; mode64 = 1'b0;
    step();
    chk("R8 all three", {61'b0, trap_illegal, trap_priv, trap_fpoff}, 64'h4);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule